// File: doc/BRIEF.md
# Non-Blocking Load Miss Scoreboard

This block keeps track of which general-purpose registers are still waiting for data from loads that missed the first-level cache. Those loads have already committed and released their reorder slot. Each outstanding miss sits in one of a small number of tagged slots, and each slot remembers its destination register. Issue logic reads a per-register pending vector and holds back any consumer of a pending register. When refill data comes back with its tag, the block drives a register-file write port in the same cycle and releases the slot. The write does not pass through the reorder buffer.

Consumers are issued optimistically, before anyone knows whether their producing load hit. When such a consumer reaches commit, its source registers are checked against the pending state held at the start of that cycle. If either one is still waiting on a miss, the block raises a redirect in that cycle. The consumer and everything younger are then fetched again. The second time, the consumer is held by the pending vector until the data has arrived. A newer miss to a register that already has an outstanding miss takes ownership of that register. The older slot's data is then dropped when it returns.

Top module: `lm_scoreboard`

## Requirements
- R1: After reset no register is pending, `load_stall` is low and `rf_we` is low. `redirect` is low for any commit check.
- R2: A miss with `miss_valid` high, `miss_rd` nonzero and a free `miss_tag` sets bit `miss_rd` of `pending`, with bit i standing for register i, from the next cycle on.
- R3: A miss to register 0 is ignored. Register 0 is never pending, and the tag stays free so that a later miss can use it.
- R4: A miss that names a tag already in use is ignored. Pending state and the slot's destination register stay unchanged.
- R5: `load_stall` is high exactly when all four tags are in use. A miss offered while it is high has no effect.
- R6: A return on a tag in use whose slot still owns its register drives, in the same cycle, `rf_we` high with `rf_waddr` set to the slot's register and `rf_wdata` equal to `ret_data`. The register stops pending and the tag becomes free from the next cycle on.
- R7: A return on a free tag causes no register-file write.
- R8: A newer miss to a register that already has an outstanding miss takes ownership of the register. When the older slot returns, nothing is written and the register stays pending until the newer slot returns.
- R9: When a return and a newer miss to the same register arrive in one cycle, the returning data is written and the register stays pending for the newer tag.
- R10: `redirect` is high in a cycle exactly when `cmt_valid` is high and `cmt_src_a` or `cmt_src_b` was pending at the start of that cycle. A return in that same cycle does not prevent the redirect. Once the data has returned, a consumer at commit raises no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A committed load missed the cache |
| miss_rd | input | 5 | Destination register of the missing load |
| miss_tag | input | 2 | Slot tag assigned to the miss |
| load_stall | output | 1 | All tags in use; load pipe must hold further misses |
| ret_valid | input | 1 | Refill data is returning |
| ret_tag | input | 2 | Tag of the returning refill |
| ret_data | input | 32 | Refill data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |
| cmt_valid | input | 1 | A consumer is at commit |
| cmt_src_a | input | 5 | First source register of the committing consumer (0 if unused) |
| cmt_src_b | input | 5 | Second source register of the committing consumer (0 if unused) |
| redirect | output | 1 | Consumer used a pending register; refetch it and younger instructions |
| pending | output | 32 | Per-register pending-miss status for issue |

## Verification
The assertions check the following on every cycle. Register 0 never becomes pending and is never written. An accepted miss shows up in the pending vector. A register that has been written stops pending unless a same-cycle miss to it took ownership. A return on a free tag never writes. A redirect needs a committing consumer with a nonzero source. Only the bench's scenarios can show the rest: that the write carries the right register and data, that a superseded slot stays silent while the newer one still owns the register, that misses offered while all tags are busy or onto a busy tag leave the slot contents untouched, and that a redirect fires only for exactly the registers that are pending.

// File: rtl/lm_scoreboard.sv
module lm_scoreboard #(
  parameter int NREG = 32,
  parameter int NTAG = 4,
  parameter int DW   = 32,
  localparam int RW  = $clog2(NREG),
  localparam int TW  = $clog2(NTAG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            miss_valid,
  input  logic [RW-1:0]   miss_rd,
  input  logic [TW-1:0]   miss_tag,
  output logic            load_stall,
  input  logic            ret_valid,
  input  logic [TW-1:0]   ret_tag,
  input  logic [DW-1:0]   ret_data,
  output logic            rf_we,
  output logic [RW-1:0]   rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  input  logic            cmt_valid,
  input  logic [RW-1:0]   cmt_src_a,
  input  logic [RW-1:0]   cmt_src_b,
  output logic            redirect,
  output logic [NREG-1:0] pending
);

  logic [NTAG-1:0] busy_q, live_q;
  logic [RW-1:0]   dst_q [NTAG];

  wire miss_ok = miss_valid && !busy_q[miss_tag] && (miss_rd != '0);
  wire ret_hit = ret_valid && busy_q[ret_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      live_q <= '0;
      for (int t = 0; t < NTAG; t++) dst_q[t] <= '0;
    end else begin
      for (int t = 0; t < NTAG; t++) begin
        if (ret_hit && ret_tag == TW'(t)) begin
          busy_q[t] <= 1'b0;
          live_q[t] <= 1'b0;
        end
        if (miss_ok && miss_tag != TW'(t) && live_q[t] && dst_q[t] == miss_rd)
          live_q[t] <= 1'b0;
        if (miss_ok && miss_tag == TW'(t)) begin
          busy_q[t] <= 1'b1;
          live_q[t] <= 1'b1;
          dst_q[t]  <= miss_rd;
        end
      end
    end
  end

  always_comb begin
    pending = '0;
    for (int t = 0; t < NTAG; t++)
      if (live_q[t]) pending[dst_q[t]] = 1'b1;
  end

  assign load_stall = &busy_q;
  assign rf_we      = ret_hit && live_q[ret_tag];
  assign rf_waddr   = dst_q[ret_tag];
  assign rf_wdata   = ret_data;
  assign redirect   = cmt_valid && (pending[cmt_src_a] || pending[cmt_src_b]);

endmodule

// File: rtl/lm_scoreboard_chk.sv
module lm_scoreboard_chk #(
  parameter int NREG = 32,
  parameter int NTAG = 4,
  parameter int RW   = 5,
  parameter int TW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            miss_valid,
  input logic [RW-1:0]   miss_rd,
  input logic [TW-1:0]   miss_tag,
  input logic            ret_valid,
  input logic [TW-1:0]   ret_tag,
  input logic            rf_we,
  input logic [RW-1:0]   rf_waddr,
  input logic            cmt_valid,
  input logic [RW-1:0]   cmt_src_a,
  input logic [RW-1:0]   cmt_src_b,
  input logic            redirect,
  input logic [NREG-1:0] pending,
  input logic [NTAG-1:0] busy
);

  assert_r0_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pending[0]);

  assert_no_r0_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != '0);

  assert_miss_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_rd != '0 && !busy[miss_tag]) |=> pending[$past(miss_rd)]);

  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !(miss_valid && miss_rd == rf_waddr)) |=> !pending[$past(rf_waddr)]);

  assert_free_tag_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !busy[ret_tag]) |-> !rf_we);

  assert_redirect_needs_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (cmt_valid && (cmt_src_a != '0 || cmt_src_b != '0)));

endmodule

bind lm_scoreboard lm_scoreboard_chk #(.NREG(NREG), .NTAG(NTAG), .RW(RW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_rd(miss_rd),
  .miss_tag(miss_tag), .ret_valid(ret_valid), .ret_tag(ret_tag), .rf_we(rf_we),
  .rf_waddr(rf_waddr), .cmt_valid(cmt_valid), .cmt_src_a(cmt_src_a),
  .cmt_src_b(cmt_src_b), .redirect(redirect), .pending(pending), .busy(busy_q)
);

// File: tb/lm_scoreboard_tb.sv
`timescale 1ns/1ps
module lm_scoreboard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [4:0]  miss_rd = '0;
  logic [1:0]  miss_tag = '0;
  logic        load_stall;
  logic        ret_valid = 1'b0;
  logic [1:0]  ret_tag = '0;
  logic [31:0] ret_data = '0;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        cmt_valid = 1'b0;
  logic [4:0]  cmt_src_a = '0;
  logic [4:0]  cmt_src_b = '0;
  logic        redirect;
  logic [31:0] pending;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  lm_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_rd(miss_rd),
    .miss_tag(miss_tag), .load_stall(load_stall), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .ret_data(ret_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .cmt_valid(cmt_valid), .cmt_src_a(cmt_src_a),
    .cmt_src_b(cmt_src_b), .redirect(redirect), .pending(pending)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic idle;
    miss_valid = 1'b0; ret_valid = 1'b0; cmt_valid = 1'b0;
    cmt_src_a = '0; cmt_src_b = '0;
  endtask

  task automatic miss(input int r, input int t);
    idle(); miss_valid = 1'b1; miss_rd = 5'(r); miss_tag = 2'(t);
  endtask

  task automatic ret(input int t, input logic [31:0] d);
    idle(); ret_valid = 1'b1; ret_tag = 2'(t); ret_data = d;
  endtask

  function automatic logic [31:0] bit_of(input int r);
    return (r == 0) ? 32'h0 : (32'h1 << r);
  endfunction

  initial begin
    #800000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk("R1 pending", pending, 0);
    chk("R1 stall", load_stall, 0);
    chk("R1 rf_we", rf_we, 0);
    for (int s = 0; s < 32; s++) begin
      cmt_valid = 1'b1; cmt_src_a = 5'(s); cmt_src_b = 5'(31 - s); #1;
      chk("R1 redirect", redirect, 0);
    end
    idle();

    for (int r = 0; r < 32; r++) begin
      for (int t = 0; t < 4; t++) begin
        miss(r, t); tick(); idle(); #1;
        chk(r == 0 ? "R3 r0 pending" : "R2 pending", pending, bit_of(r));
        for (int s = 0; s < 32; s++) begin
          cmt_valid = 1'b1; cmt_src_a = 5'(s); cmt_src_b = '0; #1;
          chk("R10 redirect src_a", redirect, (r != 0 && s == r));
          cmt_src_a = '0; cmt_src_b = 5'(s); #1;
          chk("R10 redirect src_b", redirect, (r != 0 && s == r));
        end
        ret(t, 32'hA500_0000 | 32'(r << 8) | 32'(t)); #1;
        chk(r == 0 ? "R7 free tag write" : "R6 rf_we", rf_we, (r != 0));
        if (r != 0) begin
          chk("R6 waddr", rf_waddr, r);
          chk("R6 wdata", rf_wdata, 32'hA500_0000 | 32'(r << 8) | 32'(t));
        end
        tick(); idle(); #1;
        chk("R6 cleared", pending, 0);
        cmt_valid = 1'b1; cmt_src_a = 5'(r); #1;
        chk("R10 no redirect after data", redirect, 0);
        idle();
      end
    end

    miss(0, 1); tick();
    miss(3, 1); tick(); idle(); #1;
    chk("R3 tag left free", pending, bit_of(3));
    ret(1, 32'h33); tick(); idle(); #1;

    for (int t = 0; t < 4; t++) begin
      miss(5 + t, t); #1;
      chk("R5 stall while filling", load_stall, 0);
      tick();
    end
    idle(); #1;
    chk("R5 stall full", load_stall, 1);
    miss(9, 0); tick(); idle(); #1;
    chk("R5 miss while full ignored", pending, bit_of(5) | bit_of(6) | bit_of(7) | bit_of(8));
    ret(2, 32'h77); #1;
    chk("R6 addr tag2", rf_waddr, 7);
    tick(); idle(); #1;
    chk("R5 stall released", load_stall, 0);
    chk("R6 pending after tag2", pending, bit_of(5) | bit_of(6) | bit_of(8));
    miss(10, 1); tick(); idle(); #1;
    chk("R4 busy tag ignored", pending, bit_of(5) | bit_of(6) | bit_of(8));
    ret(1, 32'h66); #1;
    chk("R4 slot register kept", rf_waddr, 6);
    chk("R4 slot write", rf_we, 1);
    tick(); ret(0, 32'h55); tick(); ret(3, 32'h88); tick(); idle(); #1;
    chk("R6 all drained", pending, 0);

    ret(3, 32'hDEAD); #1;
    chk("R7 free tag no write", rf_we, 0);
    tick(); idle();

    miss(12, 0); tick();
    miss(12, 1); tick(); idle(); #1;
    chk("R8 pending", pending, bit_of(12));
    ret(0, 32'h1200); #1;
    chk("R8 stale not written", rf_we, 0);
    tick(); idle(); #1;
    chk("R8 still pending", pending, bit_of(12));
    ret(1, 32'h1201); #1;
    chk("R8 newer written", rf_we, 1);
    chk("R8 newer data", rf_wdata, 32'h1201);
    tick(); idle(); #1;
    chk("R8 cleared", pending, 0);

    miss(14, 2); tick();
    idle(); ret_valid = 1'b1; ret_tag = 2'd2; ret_data = 32'h1402;
    miss_valid = 1'b1; miss_rd = 5'd14; miss_tag = 2'd3; #1;
    chk("R9 old data written", rf_we, 1);
    chk("R9 old addr", rf_waddr, 14);
    tick(); idle(); #1;
    chk("R9 pending for newer", pending, bit_of(14));
    ret(3, 32'h1403); #1;
    chk("R9 newer written", rf_we, 1);
    tick(); idle(); #1;
    chk("R9 cleared", pending, 0);

    miss(20, 0); tick();
    ret(0, 32'h2000); cmt_valid = 1'b1; cmt_src_b = 5'd20; #1;
    chk("R10 redirect with same-cycle return", redirect, 1);
    tick(); idle(); cmt_valid = 1'b1; cmt_src_b = 5'd20; #1;
    chk("R10 held consumer no redirect", redirect, 0);
    idle(); tick();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule